// File: doc/BRIEF.md
# Ring-Rotating Block Matrix Multiplier

The block multiplies two square integer matrices of order N with P processing elements joined in a ring. Each element keeps a band of N/P rows of the left operand, a double-buffered copy of one band of N/P columns of the right operand, its own result store and a single multiply-accumulate unit. In each phase, every element forms the result tile for the row band it owns and the column band it holds. While it does so, it streams that column band into the idle buffer of the next element around the ring. After P phases every element has seen every column band, and the full product sits in the distributed result stores.

Operands arrive after a start pulse as one qualified stream: the left matrix first, then the right matrix, both in row-major order. A fixed controller runs the load, compute and rotation sequence with no software involvement. When the last tile is written, a done flag rises. The product can then be read one element at a time through a row/column address port.

Top module: `ring_mmul`

## Requirements
- R1: After reset, done_o is low and rd_data_o is zero. Beats on in_valid_i before the first start_i are discarded and do not reach the operand stores.
- R2: After start_i, the first N*N accepted beats fill A and the next N*N fill B, each in row-major order (beat index = row*N + col). A cycle with in_valid_i low accepts no beat and does not advance the order.
- R3: The stored product equals the exact unsigned sum over k of A[i][k]*B[k][j], held at width AW = 2*DW + clog2(N) with no truncation. This also holds when every operand is at its maximum value.
- R4: done_o rises exactly N*N*N/P clock cycles after the edge that accepts the last B beat. Ring transfers add no stall cycles.
- R5: While done_o is high, rd_data_o shows C[rd_row_i][rd_col_i] one clock cycle after the address is applied.
- R6: While the product is being computed, start_i and in_valid_i are ignored. Neither the result nor the R4 latency changes.
- R7: start_i while done_o is high begins a new load, and done_o is low on the next cycle. The next product replaces the previous one in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins loading when idle or done |
| in_valid_i | input | 1 | Qualifies in_data_i during load |
| in_data_i | input | DW | Operand element, A then B, row-major |
| rd_row_i | input | clog2(N) | Result row to read |
| rd_col_i | input | clog2(N) | Result column to read |
| rd_data_o | output | AW | Registered result element |
| done_o | output | 1 | Product complete and readable |

## Verification
The bench builds the block with N=6, P=3 and DW=8. This gives two-row bands, three ring phases and a full rotation in which every column band visits every element. All 36 result elements are read back after every run, so every tile and every column-block placement is checked against a product computed in the bench. The maximum-operand run at this width reaches the top of the 19-bit accumulator. The cycle count checks the 72-cycle compute window, and separate runs add load bubbles, mid-compute noise on start and valid, and a restart straight from the done state.

// File: rtl/rmm_pkg.sv
package rmm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_CALC = 2'd2,
    ST_DONE = 2'd3
  } rmm_state_e;
endpackage

// File: rtl/rmm_ctrl.sv
module rmm_ctrl
  import rmm_pkg::*;
#(
  parameter int N = 8,
  parameter int P = 4,
  localparam int BS = N / P,
  localparam int BLK = N * BS,
  localparam int IW = $clog2(N),
  localparam int BW = (BS > 1) ? $clog2(BS) : 1,
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int XW = $clog2(BLK + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          in_valid_i,
  output logic          ld_we_o,
  output logic          ld_b_o,
  output logic [IW-1:0] ld_row_o,
  output logic [IW-1:0] ld_col_o,
  output logic          mac_en_o,
  output logic          first_k_o,
  output logic          last_k_o,
  output logic [IW-1:0] k_o,
  output logic [BW-1:0] r_o,
  output logic [BW-1:0] c_o,
  output logic [PW-1:0] phase_o,
  output logic          bank_o,
  output logic          xfer_we_o,
  output logic [XW-1:0] xfer_addr_o,
  output logic          done_o
);
  localparam int TOTAL = N * N * N / P;
  localparam int TW = $clog2(TOTAL + 1);

  rmm_state_e    state_q;
  logic [IW-1:0] lrow_q, lcol_q, k_q;
  logic          lb_q, bank_q;
  logic [BW-1:0] r_q, c_q;
  logic [PW-1:0] ph_q;
  logic [XW-1:0] x_q;
  logic          last_lc, last_lr, last_k, last_c, last_r, last_ph;

  assign last_lc = lcol_q == IW'(N - 1);
  assign last_lr = lrow_q == IW'(N - 1);
  assign last_k  = k_q == IW'(N - 1);
  assign last_c  = c_q == BW'(BS - 1);
  assign last_r  = r_q == BW'(BS - 1);
  assign last_ph = ph_q == PW'(P - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lrow_q  <= '0;
      lcol_q  <= '0;
      lb_q    <= 1'b0;
      k_q     <= '0;
      r_q     <= '0;
      c_q     <= '0;
      ph_q    <= '0;
      bank_q  <= 1'b0;
      x_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_LOAD;
            lrow_q  <= '0;
            lcol_q  <= '0;
            lb_q    <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (in_valid_i) begin
            if (last_lc) begin
              lcol_q <= '0;
              if (last_lr) begin
                lrow_q <= '0;
                if (lb_q) begin
                  state_q <= ST_CALC;
                  k_q     <= '0;
                  r_q     <= '0;
                  c_q     <= '0;
                  ph_q    <= '0;
                  bank_q  <= 1'b0;
                  x_q     <= '0;
                end else begin
                  lb_q <= 1'b1;
                end
              end else begin
                lrow_q <= lrow_q + 1'b1;
              end
            end else begin
              lcol_q <= lcol_q + 1'b1;
            end
          end
        end
        ST_CALC: begin
          if (x_q < XW'(BLK)) x_q <= x_q + 1'b1;
          if (last_k) begin
            k_q <= '0;
            if (last_c) begin
              c_q <= '0;
              if (last_r) begin
                r_q    <= '0;
                x_q    <= '0;
                bank_q <= ~bank_q;
                ph_q   <= last_ph ? '0 : ph_q + 1'b1;
                if (last_ph) state_q <= ST_DONE;
              end else begin
                r_q <= r_q + 1'b1;
              end
            end else begin
              c_q <= c_q + 1'b1;
            end
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ld_we_o     = (state_q == ST_LOAD) && in_valid_i;
  assign ld_b_o      = lb_q;
  assign ld_row_o    = lrow_q;
  assign ld_col_o    = lcol_q;
  assign mac_en_o    = state_q == ST_CALC;
  assign first_k_o   = k_q == '0;
  assign last_k_o    = last_k;
  assign k_o         = k_q;
  assign r_o         = r_q;
  assign c_o         = c_q;
  assign phase_o     = ph_q;
  assign bank_o      = bank_q;
  assign xfer_we_o   = mac_en_o && (x_q < XW'(BLK));
  assign xfer_addr_o = x_q;
  assign done_o      = state_q == ST_DONE;

  // independent compute-cycle counter for latency checks
  logic [TW-1:0] chk_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_cnt_q <= '0;
    else if (state_q == ST_LOAD) chk_cnt_q <= '0;
    else if (state_q == ST_CALC && chk_cnt_q < TW'(TOTAL + 1)) chk_cnt_q <= chk_cnt_q + 1'b1;
  end

  assert_calc_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> chk_cnt_q == TW'(TOTAL));

  assert_ring_complete_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_en_o && last_k && last_c && last_r) |-> x_q == XW'(BLK));

  assert_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CALC && start_i) |=> state_q != ST_LOAD);

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (state_q == ST_LOAD && !done_o));
endmodule

// File: rtl/rmm_pe.sv
module rmm_pe #(
  parameter int N = 8,
  parameter int P = 4,
  parameter int DW = 16,
  parameter int AW = 2 * DW + $clog2(N),
  localparam int BS = N / P,
  localparam int BLK = N * BS,
  localparam int AAW = $clog2(BS * N),
  localparam int BBW = $clog2(2 * BLK),
  localparam int IW = $clog2(N),
  localparam int BW = (BS > 1) ? $clog2(BS) : 1,
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int XW = $clog2(BLK + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           a_we_i,
  input  logic [AAW-1:0] a_addr_i,
  input  logic           b_we_i,
  input  logic [BBW-1:0] b_addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           mac_en_i,
  input  logic           first_k_i,
  input  logic           last_k_i,
  input  logic [IW-1:0]  k_i,
  input  logic [BW-1:0]  r_i,
  input  logic [BW-1:0]  c_i,
  input  logic [PW-1:0]  cblk_i,
  input  logic           bank_i,
  input  logic           xfer_we_i,
  input  logic [XW-1:0]  xfer_addr_i,
  input  logic [DW-1:0]  ring_i,
  output logic [DW-1:0]  ring_o,
  input  logic [AAW-1:0] rd_addr_i,
  output logic [AW-1:0]  rd_data_o
);
  logic [DW-1:0] a_mem [BS*N];
  logic [DW-1:0] b_mem [2*BLK];
  logic [AW-1:0] c_mem [BS*N];

  logic [AAW-1:0] a_idx, c_idx;
  logic [BBW-1:0] b_idx, tx_idx, rx_idx;
  logic [AW-1:0]  prod, sum, acc_q;

  always_comb begin
    a_idx  = AAW'(int'(r_i) * N + int'(k_i));
    c_idx  = AAW'(int'(r_i) * N + int'(cblk_i) * BS + int'(c_i));
    b_idx  = BBW'(int'(bank_i) * BLK + int'(k_i) * BS + int'(c_i));
    tx_idx = BBW'(int'(bank_i) * BLK + int'(xfer_addr_i));
    rx_idx = BBW'(int'(!bank_i) * BLK + int'(xfer_addr_i));
    prod   = AW'(a_mem[a_idx]) * AW'(b_mem[b_idx]);
    sum    = (first_k_i ? '0 : acc_q) + prod;
  end

  assign ring_o    = b_mem[tx_idx];
  assign rd_data_o = c_mem[rd_addr_i];

  always_ff @(posedge clk_i) begin
    if (a_we_i) a_mem[a_addr_i] <= wdata_i;
    if (b_we_i) b_mem[b_addr_i] <= wdata_i;
    else if (xfer_we_i) b_mem[rx_idx] <= ring_i;  // fill the idle bank
    if (mac_en_i && last_k_i) c_mem[c_idx] <= sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else if (mac_en_i) acc_q <= sum;
  end

  assert_acc_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_en_i && first_k_i) |=> acc_q == $past(prod));

  assert_no_load_in_calc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_en_i |-> !(a_we_i || b_we_i));
endmodule

// File: rtl/ring_mmul.sv
module ring_mmul #(
  parameter int N = 8,
  parameter int P = 4,
  parameter int DW = 16,
  parameter int AW = 2 * DW + $clog2(N),
  localparam int BS = N / P,
  localparam int BLK = N * BS,
  localparam int AAW = $clog2(BS * N),
  localparam int BBW = $clog2(2 * BLK),
  localparam int IW = $clog2(N),
  localparam int BW = (BS > 1) ? $clog2(BS) : 1,
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int XW = $clog2(BLK + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [IW-1:0] rd_row_i,
  input  logic [IW-1:0] rd_col_i,
  output logic [AW-1:0] rd_data_o,
  output logic          done_o
);
  logic          ld_we, ld_b, mac_en, first_k, last_k, bank, xfer_we;
  logic [IW-1:0] ld_row, ld_col, k;
  logic [BW-1:0] r, c;
  logic [PW-1:0] phase;
  logic [XW-1:0] xfer_addr;

  rmm_ctrl #(.N(N), .P(P)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .in_valid_i,
    .ld_we_o(ld_we), .ld_b_o(ld_b), .ld_row_o(ld_row), .ld_col_o(ld_col),
    .mac_en_o(mac_en), .first_k_o(first_k), .last_k_o(last_k), .k_o(k),
    .r_o(r), .c_o(c), .phase_o(phase), .bank_o(bank),
    .xfer_we_o(xfer_we), .xfer_addr_o(xfer_addr), .done_o
  );

  logic [AAW-1:0] a_addr, rd_local;
  logic [BBW-1:0] b_addr;
  logic [PW-1:0]  rd_pe;
  logic [P-1:0]   a_we, b_we;
  logic [DW-1:0]  ring [P];
  logic [AW-1:0]  pe_rd [P];

  assign a_addr   = AAW'((int'(ld_row) % BS) * N + int'(ld_col));
  assign b_addr   = BBW'(int'(ld_row) * BS + int'(ld_col) % BS);
  assign rd_pe    = PW'(int'(rd_row_i) / BS);
  assign rd_local = AAW'((int'(rd_row_i) % BS) * N + int'(rd_col_i));

  for (genvar g = 0; g < P; g++) begin : g_pe
    logic [PW-1:0] cblk;
    assign a_we[g] = ld_we && !ld_b && (int'(ld_row) / BS == g);
    assign b_we[g] = ld_we && ld_b && (int'(ld_col) / BS == g);
    // column band held by element g in the current phase
    assign cblk = PW'((g + P - int'(phase)) % P);

    rmm_pe #(.N(N), .P(P), .DW(DW), .AW(AW)) u_pe (
      .clk_i, .rst_ni,
      .a_we_i(a_we[g]), .a_addr_i(a_addr),
      .b_we_i(b_we[g]), .b_addr_i(b_addr), .wdata_i(in_data_i),
      .mac_en_i(mac_en), .first_k_i(first_k), .last_k_i(last_k),
      .k_i(k), .r_i(r), .c_i(c), .cblk_i(cblk), .bank_i(bank),
      .xfer_we_i(xfer_we), .xfer_addr_i(xfer_addr),
      .ring_i(ring[(g + P - 1) % P]), .ring_o(ring[g]),
      .rd_addr_i(rd_local), .rd_data_o(pe_rd[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else rd_data_o <= pe_rd[rd_pe];
  end

  assert_load_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({a_we, b_we}));

  assert_load_needs_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ({a_we, b_we} == '0));
endmodule

// File: tb/ring_mmul_test.sv
module ring_mmul_test;
  localparam int N = 6;
  localparam int P = 3;
  localparam int DW = 8;
  localparam int AW = 2 * DW + $clog2(N);
  localparam int IW = $clog2(N);
  localparam int LAT = N * N * N / P;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [IW-1:0] rd_row = '0;
  logic [IW-1:0] rd_col = '0;
  logic [AW-1:0] rd_data;
  logic          done;

  int checks = 0;
  int errors = 0;
  int ma [N][N];
  int mb [N][N];

  always #4 clk = ~clk;

  ring_mmul #(.N(N), .P(P), .DW(DW), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .in_valid_i(in_valid),
    .in_data_i(in_data), .rd_row_i(rd_row), .rd_col_i(rd_col),
    .rd_data_o(rd_data), .done_o(done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic load(input bit gaps);
    for (int idx = 0; idx < 2 * N * N; idx++) begin
      if (gaps && (idx % 5 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'h5A;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (idx < N * N) ? DW'(ma[idx / N][idx % N])
                               : DW'(mb[(idx - N * N) / N][(idx - N * N) % N]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  task automatic wait_done(input bit noise, input string req);
    int cyc = 0;
    if (noise) begin
      start    = 1'b1;
      in_valid = 1'b1;
      in_data  = 8'hAA;
    end
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (done || cyc > 4 * LAT) break;
      @(negedge clk);
      if (noise && cyc < 20) begin
        start    = cyc[0];
        in_valid = 1'b1;
        in_data  = DW'(cyc * 37);
      end else begin
        start    = 1'b0;
        in_valid = 1'b0;
      end
    end
    start    = 1'b0;
    in_valid = 1'b0;
    check(req, cyc, LAT);
  endtask

  task automatic check_product(input string req);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        longint exp = 0;
        for (int kk = 0; kk < N; kk++) exp += longint'(ma[i][kk]) * mb[kk][j];
        @(negedge clk);
        rd_row = IW'(i);
        rd_col = IW'(j);
        @(posedge clk);
        #1;
        check(req, rd_data, exp);
      end
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;

    // R1: beats before start are dropped; A = identity, so C must equal B
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = (i == j) ? 1 : 0;
        mb[i][j] = (i * 7 + j * 3 + 1) % 256;
      end
    repeat (5) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'hFF;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 idle done", done, 0);
    pulse_start();
    load(1'b0);
    wait_done(1'b0, "R4 latency identity");
    check_product("R1 R2 R5 identity product");

    // R2 with load bubbles, R7 restart from done
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = (i + 2 * j) % 11;
        mb[i][j] = (3 * i + 5 * j + 1) % 13;
      end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 done drops on restart", done, 0);
    load(1'b1);
    wait_done(1'b0, "R4 latency gapped load");
    check_product("R2 R3 R7 gapped load product");

    // R3 maximum operands, R6 noise on start/valid during compute
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = 255;
        mb[i][j] = 255;
      end
    pulse_start();
    load(1'b0);
    wait_done(1'b1, "R6 latency under noise");
    check_product("R3 R6 max operand product");

    // asymmetric pattern exercises every column band placement
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = (i * 41 + j * 17 + 3) % 256;
        mb[i][j] = (i * j * 29 + j + 200) % 256;
      end
    pulse_start();
    load(1'b0);
    wait_done(1'b0, "R4 latency asymmetric");
    check_product("R3 R5 asymmetric product");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule